// File: doc/BRIEF.md
# HDLC Receive FIFO with Frame Status Words

This block is the receive buffer between an HDLC deframer and a microcontroller. The deframer hands over payload bytes one at a time and, at the close of each frame, a short status word. Both go into one shared ring in arrival order. Bit 8 of each stored entry tells the reader whether the entry is a payload byte or a status word. The block keeps a separate count of the status words it holds, because the number of frames that can wait in the buffer is limited apart from the byte capacity.

Events are collected in a sticky interrupt register, and a single read strobe clears the whole register. The events are: the status-word limit was reached, an end-of-frame status arrived, an abort status arrived, the fill level reached a programmable threshold, and an overrun occurred. The threshold flag has hysteresis. It fires once when the level reaches the threshold, and it can fire again only after the level has dropped below the threshold.

On an overrun the current frame is closed with an overrun status word, provided a status word can still be stored. After that the receiver ignores every further write until software pulses the reinitialise input.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty: `rd_vld` is 0, `fill_level` is 0 and `irq_flags` is 0.
- R2: Writes are stored only while `frame_acc` is 1, and they are read back in arrival order. A payload byte reads as {0, byte}. A status word reads as {1, 4'b0, bits}, where bit 0 is end-of-frame, bit 1 is abort, bit 2 is overrun and bit 3 is CRC error. `rd_data` shows the oldest entry, and a pulse on `rd_en` removes it.
- R3: The FIFO holds at most MAX_STAT status words. The status write that brings the count to MAX_STAT sets `irq_flags[0]`.
- R4: A stored status word with its end-of-frame bit set sets `irq_flags[1]`. A stored status word with its abort bit set sets `irq_flags[2]`.
- R5: `irq_flags[3]` is set when `fill_level` becomes greater than or equal to `thr_level`. It is not set again until `fill_level` has been below `thr_level` and then reaches it once more.
- R6: A pulse on `irq_rd` clears every bit of `irq_flags`. An event in the same cycle as the pulse remains set.
- R7: A payload byte is refused when the FIFO holds DEPTH-1 entries or MAX_STAT status words. A status word still fits in the last entry. A refused write sets the overrun flag `irq_flags[4]`.
- R8: When a payload byte is refused and fewer than MAX_STAT status words are held, a status word with only its overrun bit set (entry 0x104) is stored to close the frame.
- R9: After an overrun every byte and status write is ignored, even once space has been freed. A pulse on `reinit` empties the FIFO and accepts writes again. It leaves `irq_flags` unchanged.
- R10: A pulse on `rd_en` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reinit | input | 1 | Empties the FIFO and ends the overrun lockout |
| frame_acc | input | 1 | The current frame passed address filtering |
| byte_vld | input | 1 | A payload byte is presented |
| byte_data | input | 8 | Payload byte |
| stat_vld | input | 1 | A status word is presented (wins over `byte_vld`) |
| stat_bits | input | 4 | Status bits: EOF, abort, overrun, CRC error (bits 0 to 3) |
| rd_en | input | 1 | Removes the oldest entry |
| rd_data | output | 9 | Oldest entry; bit 8 marks a status word |
| rd_vld | output | 1 | FIFO is not empty |
| fill_level | output | $clog2(DEPTH+1) | Number of stored entries |
| thr_level | input | $clog2(DEPTH+1) | Fill threshold for the interrupt |
| irq_rd | input | 1 | Clears the interrupt register |
| irq_flags | output | 5 | Status full, EOF, abort, threshold, overrun |

## Verification
The bench uses a 16-entry, 4-status configuration. It writes frames of every payload length from 1 to 14, which shows whether ordering, the entry tag and the status layout hold at every wrap position. It sweeps the threshold across every level, rising, dropping by one and rising again, so that a flag that re-fires without hysteresis can be told apart from one that never re-arms. Overruns are caused in two ways, first by the status count and then by the byte count. A status word is also placed into the reserved last entry. Together these separate the closing-word rule, the reserved-slot rule and the lockout that persists after entries have been read.

// File: rtl/hdlc_rxf_pkg.sv
package hdlc_rxf_pkg;
    // status word bit positions (low bits of a status entry)
    localparam int ST_EOF  = 0;
    localparam int ST_ABRT = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_CRC  = 3;
    localparam int ST_W    = 4;

    // payload width and stored entry width (tag bit on top)
    localparam int BYTE_W  = 8;
    localparam int ENT_W   = BYTE_W + 1;

    // interrupt register bit positions
    localparam int IRQ_SFULL = 0;
    localparam int IRQ_EOF   = 1;
    localparam int IRQ_ABRT  = 2;
    localparam int IRQ_THR   = 3;
    localparam int IRQ_OVR   = 4;
    localparam int IRQ_W     = 5;

    typedef logic [IRQ_W-1:0] irq_vec_t;
    typedef logic [ENT_W-1:0] entry_t;
endpackage

// File: rtl/hdlc_rxf_ring.sv
module hdlc_rxf_ring
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_STAT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear,
    input  logic                          push,
    input  entry_t                        push_word,
    input  logic                          pop,
    output entry_t                        head,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic [$clog2(MAX_STAT+1)-1:0] stat_cnt
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);
    localparam int SW = $clog2(MAX_STAT+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
        logic [SW-1:0] sc;
    } ring_t;

    ring_t  r_q, r_d;
    entry_t mem [DEPTH];
    logic   pop_ok;

    assign head   = mem[r_q.rp];
    assign pop_ok = pop && (r_q.lvl != '0);

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d = '0;
        end else begin
            if (push)
                r_d.wp = (r_q.wp == LAST) ? '0 : r_q.wp + AW'(1);
            if (pop_ok)
                r_d.rp = (r_q.rp == LAST) ? '0 : r_q.rp + AW'(1);
            r_d.lvl = r_q.lvl + LW'(push) - LW'(pop_ok);
            r_d.sc  = r_q.sc + SW'(push && push_word[ENT_W-1])
                             - SW'(pop_ok && head[ENT_W-1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clear) mem[r_q.wp] <= push_word;
    end

    assign level    = r_q.lvl;
    assign stat_cnt = r_q.sc;
endmodule

// File: rtl/hdlc_rxf_ctl.sv
module hdlc_rxf_ctl
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_STAT = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reinit,
    input  logic                          frame_acc,
    input  logic                          byte_vld,
    input  logic [BYTE_W-1:0]             byte_data,
    input  logic                          stat_vld,
    input  logic [ST_W-1:0]               stat_bits,
    input  logic [$clog2(DEPTH+1)-1:0]    level,
    input  logic [$clog2(MAX_STAT+1)-1:0] stat_cnt,
    output logic                          push,
    output entry_t                        push_word,
    output irq_vec_t                      ev,
    output logic                          locked
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int SW = $clog2(MAX_STAT+1);

    typedef struct packed {
        logic lock;
    } ctl_t;

    ctl_t r_q, r_d;
    logic take_stat, take_byte;
    logic stat_room, stat_fit, byte_fit;

    function automatic entry_t mk_stat(input logic [ST_W-1:0] b);
        return {1'b1, {(BYTE_W-ST_W){1'b0}}, b};
    endfunction

    always_comb begin
        r_d       = r_q;
        push      = 1'b0;
        push_word = '0;
        ev        = '0;

        take_stat = !r_q.lock && !reinit && frame_acc && stat_vld;
        take_byte = !r_q.lock && !reinit && frame_acc && byte_vld && !stat_vld;
        stat_room = stat_cnt < SW'(MAX_STAT);
        stat_fit  = stat_room && (level < LW'(DEPTH));
        byte_fit  = stat_room && (level < LW'(DEPTH-1));

        if (take_stat) begin
            if (stat_fit) begin
                push            = 1'b1;
                push_word       = mk_stat(stat_bits);
                ev[IRQ_EOF]     = stat_bits[ST_EOF];
                ev[IRQ_ABRT]    = stat_bits[ST_ABRT];
                ev[IRQ_SFULL]   = (stat_cnt == SW'(MAX_STAT-1));
            end else begin
                ev[IRQ_OVR] = 1'b1;
                r_d.lock    = 1'b1;
            end
        end else if (take_byte) begin
            if (byte_fit) begin
                push      = 1'b1;
                push_word = {1'b0, byte_data};
            end else begin
                ev[IRQ_OVR] = 1'b1;
                r_d.lock    = 1'b1;
                if (stat_fit) begin
                    // close the frame in the reserved entry
                    push          = 1'b1;
                    push_word     = mk_stat(ST_W'(1 << ST_OVR));
                    ev[IRQ_SFULL] = (stat_cnt == SW'(MAX_STAT-1));
                end
            end
        end

        if (reinit) r_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign locked = r_q.lock;
endmodule

// File: rtl/hdlc_rxf_irq.sv
module hdlc_rxf_irq
    import hdlc_rxf_pkg::*;
#(
    parameter int LW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reinit,
    input  irq_vec_t      ev_in,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] thr,
    input  logic          irq_rd,
    output irq_vec_t      irq
);
    typedef struct packed {
        irq_vec_t flags;
        logic     armed;
    } irq_t;

    irq_t r_q, r_d;
    logic thr_hit;

    always_comb begin
        r_d     = r_q;
        thr_hit = r_q.armed && !reinit && (level >= thr);

        if (reinit)            r_d.armed = 1'b1;
        else if (thr_hit)      r_d.armed = 1'b0;
        else if (level < thr)  r_d.armed = 1'b1;

        r_d.flags = (irq_rd ? irq_vec_t'(0) : r_q.flags) | ev_in;
        if (thr_hit) r_d.flags[IRQ_THR] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{flags: '0, armed: 1'b1};
        else        r_q <= r_d;
    end

    assign irq = r_q.flags;
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_STAT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reinit,
    input  logic                       frame_acc,
    input  logic                       byte_vld,
    input  logic [7:0]                 byte_data,
    input  logic                       stat_vld,
    input  logic [3:0]                 stat_bits,
    input  logic                       rd_en,
    output logic [8:0]                 rd_data,
    output logic                       rd_vld,
    output logic [$clog2(DEPTH+1)-1:0] fill_level,
    input  logic [$clog2(DEPTH+1)-1:0] thr_level,
    input  logic                       irq_rd,
    output logic [4:0]                 irq_flags
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int SW = $clog2(MAX_STAT+1);

    logic [LW-1:0] level_w;
    logic [SW-1:0] stat_cnt_w;
    logic          push_w;
    entry_t        push_word_w;
    entry_t        head_w;
    irq_vec_t      ev_w;
    irq_vec_t      irq_w;
    logic          locked_w;

    hdlc_rxf_ring #(.DEPTH(DEPTH), .MAX_STAT(MAX_STAT)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (reinit),
        .push      (push_w),
        .push_word (push_word_w),
        .pop       (rd_en && !reinit),
        .head      (head_w),
        .level     (level_w),
        .stat_cnt  (stat_cnt_w)
    );

    hdlc_rxf_ctl #(.DEPTH(DEPTH), .MAX_STAT(MAX_STAT)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reinit    (reinit),
        .frame_acc (frame_acc),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .stat_vld  (stat_vld),
        .stat_bits (stat_bits),
        .level     (level_w),
        .stat_cnt  (stat_cnt_w),
        .push      (push_w),
        .push_word (push_word_w),
        .ev        (ev_w),
        .locked    (locked_w)
    );

    hdlc_rxf_irq #(.LW(LW)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .reinit (reinit),
        .ev_in  (ev_w),
        .level  (level_w),
        .thr    (thr_level),
        .irq_rd (irq_rd),
        .irq    (irq_w)
    );

    assign rd_data    = head_w;
    assign rd_vld     = (level_w != '0);
    assign fill_level = level_w;
    assign irq_flags  = irq_w;
endmodule

// File: rtl/hdlc_rxf_chk.sv
module hdlc_rxf_chk
    import hdlc_rxf_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int MAX_STAT = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reinit,
    input logic                          rd_en,
    input logic                          rd_vld,
    input logic [$clog2(DEPTH+1)-1:0]    level,
    input logic [$clog2(MAX_STAT+1)-1:0] stat_cnt,
    input logic                          push,
    input logic                          locked,
    input irq_vec_t                      ev,
    input logic                          irq_rd,
    input irq_vec_t                      irq_flags
);
    localparam int LW = $clog2(DEPTH+1);
    localparam int SW = $clog2(MAX_STAT+1);
    localparam irq_vec_t NON_THR = ~irq_vec_t'(1 << IRQ_THR);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R7
    AST_STAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_cnt <= SW'(MAX_STAT)) && (LW'(stat_cnt) <= level)); // R3
    AST_LOCK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !push); // R9
    AST_OVR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev[IRQ_OVR] && !reinit) |=> locked); // R9
    AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ev[IRQ_OVR] |=> irq_flags[IRQ_OVR]); // R7
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rd && ev == '0) |=> ((irq_flags & NON_THR) == '0)); // R6
    AST_POP_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_vld && !push && !reinit) |=> level == $past(level) - LW'(1)); // R2
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_vld && !push && !reinit) |=> level == '0); // R10
    AST_REINIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        reinit |=> (level == '0) && (stat_cnt == '0) && !locked); // R9
endmodule

bind hdlc_rx_fifo hdlc_rxf_chk #(.DEPTH(DEPTH), .MAX_STAT(MAX_STAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reinit    (reinit),
    .rd_en     (rd_en),
    .rd_vld    (rd_vld),
    .level     (level_w),
    .stat_cnt  (stat_cnt_w),
    .push      (push_w),
    .locked    (locked_w),
    .ev        (ev_w),
    .irq_rd    (irq_rd),
    .irq_flags (irq_flags)
);

// File: tb/tb_hdlc_rx_fifo.sv
module tb_hdlc_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int MAX_STAT   = 4;
    localparam int LW         = $clog2(DEPTH+1);
    localparam int B_SF = 1, B_EOF = 2, B_AB = 4, B_THR = 8, B_OVR = 16;
    localparam int S_EOF = 1, S_AB = 2, S_OVR = 4, S_CRC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reinit = 1'b0, frame_acc = 1'b0;
    logic          byte_vld = 1'b0, stat_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic [3:0]    stat_bits = '0;
    logic          rd_en = 1'b0, irq_rd = 1'b0;
    logic [8:0]    rd_data;
    logic          rd_vld;
    logic [LW-1:0] fill_level;
    logic [LW-1:0] thr_level = '1;
    logic [4:0]    irq_flags;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_fifo #(.DEPTH(DEPTH), .MAX_STAT(MAX_STAT)) dut (
        .clk(clk), .rst_n(rst_n), .reinit(reinit), .frame_acc(frame_acc),
        .byte_vld(byte_vld), .byte_data(byte_data), .stat_vld(stat_vld),
        .stat_bits(stat_bits), .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld),
        .fill_level(fill_level), .thr_level(thr_level), .irq_rd(irq_rd),
        .irq_flags(irq_flags)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all stimulus tasks start and end at a falling edge
    task automatic put_byte(input int b, input logic acc = 1'b1);
        frame_acc = acc; byte_vld = 1'b1; byte_data = 8'(b);
        @(negedge clk);
        byte_vld = 1'b0; frame_acc = 1'b0;
    endtask

    task automatic put_stat(input int s, input logic clr = 1'b0);
        frame_acc = 1'b1; stat_vld = 1'b1; stat_bits = 4'(s); irq_rd = clr;
        @(negedge clk);
        stat_vld = 1'b0; frame_acc = 1'b0; irq_rd = 1'b0;
    endtask

    task automatic pop_one();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clr_irq();
        irq_rd = 1'b1;
        @(negedge clk);
        irq_rd = 1'b0;
    endtask

    task automatic do_reinit();
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_vld", int'(rd_vld), 0);
        check("R1 level", int'(fill_level), 0);
        check("R1 irq", int'(irq_flags), 0);

        // R2 writes outside an accepted frame are dropped
        put_byte(8'h11, 1'b0);
        settle();
        check("R2 gated level", int'(fill_level), 0);

        // R2 / R4 frames of every payload length
        for (int n = 1; n <= DEPTH-2; n++) begin
            int st;
            st = S_EOF | ((n % 2) != 0 ? S_CRC : 0);
            for (int i = 0; i < n; i++) put_byte((i*7 + n) & 255);
            put_stat(st);
            settle();
            check("R2 level", int'(fill_level), n+1);
            check("R4 eof irq", int'(irq_flags), B_EOF);
            clr_irq();
            for (int i = 0; i < n; i++) begin
                check("R2 byte", int'(rd_data), (i*7 + n) & 255);
                pop_one();
            end
            check("R2 status", int'(rd_data), 256 + st);
            pop_one();
            check("R2 empty", int'(rd_vld), 0);
        end

        // R4 abort
        put_stat(S_AB);
        settle();
        check("R4 abort irq", int'(irq_flags), B_AB);
        clr_irq();
        check("R6 cleared", int'(irq_flags), 0);
        pop_one();

        // R6 read strobe coinciding with a new event
        put_stat(S_EOF, 1'b1);
        settle();
        check("R6 same-cycle event kept", int'(irq_flags), B_EOF);
        clr_irq();
        check("R6 cleared", int'(irq_flags), 0);
        pop_one();

        // R5 threshold sweep with hysteresis
        for (int t = 1; t <= DEPTH-1; t++) begin
            do_reinit();
            thr_level = LW'(t);
            settle();
            clr_irq();
            for (int k = 1; k <= t; k++) begin
                put_byte(k);
                settle();
                check("R5 rise", (int'(irq_flags) >> 3) & 1, (k >= t) ? 1 : 0);
            end
            clr_irq();
            settle();
            check("R5 no refire at level", (int'(irq_flags) >> 3) & 1, 0);
            if (t < DEPTH-2) begin
                put_byte(8'hAA);
                settle();
                check("R5 no refire above", (int'(irq_flags) >> 3) & 1, 0);
            end
            while (int'(fill_level) >= t) pop_one();
            settle();
            check("R5 below stays clear", (int'(irq_flags) >> 3) & 1, 0);
            put_byte(8'h5A);
            settle();
            check("R5 refire", (int'(irq_flags) >> 3) & 1, 1);
        end
        thr_level = '1;
        do_reinit();
        settle();
        clr_irq();

        // R3 status-word limit, then R7/R8/R9 overrun through it
        for (int k = 1; k <= MAX_STAT; k++) begin
            put_stat(S_CRC);
            settle();
            check("R3 sfull", int'(irq_flags) & 1, (k == MAX_STAT) ? 1 : 0);
        end
        check("R3 level", int'(fill_level), MAX_STAT);
        clr_irq();
        put_byte(8'h55);
        settle();
        check("R7 ovr by status limit", int'(irq_flags), B_OVR);
        check("R8 no closing word when full", int'(fill_level), MAX_STAT);
        pop_one();
        put_byte(8'h66);
        put_stat(S_EOF);
        settle();
        check("R9 locked after space", int'(fill_level), MAX_STAT-1);
        do_reinit();
        check("R9 reinit empties", int'(rd_vld), 0);
        put_byte(8'hA5);
        check("R9 accepts after reinit", int'(fill_level), 1);
        check("R9 data after reinit", int'(rd_data), 8'hA5);
        clr_irq();

        // R7 / R8 overrun through byte capacity
        do_reinit();
        for (int i = 0; i < DEPTH-1; i++) put_byte(i);
        settle();
        check("R7 no irq before full", int'(irq_flags), 0);
        check("R7 level", int'(fill_level), DEPTH-1);
        put_byte(8'hEE);
        settle();
        check("R7 ovr irq", int'(irq_flags), B_OVR);
        check("R8 closing word stored", int'(fill_level), DEPTH);
        check("R2 first", int'(rd_data), 0);
        pop_one();
        put_byte(8'h77);
        settle();
        check("R9 ignored after pop", int'(fill_level), DEPTH-1);
        for (int i = 1; i < DEPTH-1; i++) begin
            check("R7 kept byte", int'(rd_data), i);
            pop_one();
        end
        check("R8 closing word", int'(rd_data), 256 + S_OVR);
        pop_one();
        clr_irq();

        // R7 status fits the reserved last entry
        do_reinit();
        for (int i = 0; i < DEPTH-1; i++) put_byte(i + 3);
        put_stat(S_EOF);
        settle();
        check("R7 status in last entry", int'(fill_level), DEPTH);
        check("R7 no ovr for status", int'(irq_flags), B_EOF);
        clr_irq();
        put_byte(8'h01);
        settle();
        check("R7 ovr when full", int'(irq_flags), B_OVR);
        check("R8 no room for closing", int'(fill_level), DEPTH);
        clr_irq();

        // R10 read while empty
        do_reinit();
        pop_one();
        settle();
        check("R10 empty pop level", int'(fill_level), 0);
        put_byte(8'h3C);
        check("R10 level after", int'(fill_level), 1);
        check("R10 data after", int'(rd_data), 8'h3C);

        finish_run();
    end
endmodule